// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Pending and In-Service Controller

This block holds the interrupt bookkeeping of a two-channel serial controller. For each channel it keeps a receive-pending flag, a transmit-pending flag, a sticky break flag and an in-service record held as a small state machine. From these it builds a shared pending register, a shared modified vector, and one combined active-high interrupt line. Events arrive as one-cycle strobes per channel: a byte received, a transmit byte gone, a data-register write, a data-register read, a break, a channel reset and a command byte written to the channel's command register.

The in-service state machine of each channel has four states: `SV_IDLE` (nothing in service), `SV_RX` (receive in service), `SV_TX` (transmit in service) and `SV_BOTH`. Transitions: a received byte moves any state to one with receive in service (`SV_IDLE`->`SV_RX`, `SV_TX`->`SV_BOTH`); a transmit byte gone moves `SV_IDLE`->`SV_TX` only, and is held off in `SV_RX` and `SV_BOTH`; a data read leaves receive service and, with transmit pending, enters transmit service (to `SV_TX`, else `SV_IDLE`); the clear-transmit command leaves transmit service and, with receive pending, re-enters receive service; the reset-highest-in-service command leaves `SV_RX`/`SV_BOTH` for `SV_IDLE`/`SV_TX` (to `SV_TX` when transmit is pending) and otherwise leaves `SV_TX` for `SV_IDLE`; a channel reset returns to `SV_IDLE`.

Index 0 of every per-channel port is channel A, index 1 is channel B. Interrupt enables, receive interrupt mode and the status-high selector come in as static configuration inputs from the register file around the block.

Top module: `sirq_ctrl`

## Requirements
- R1: `irq` is high exactly when, for some channel, (`tx_ie` set and transmit pending) or (its `rx_mode` field equals 01 or 10 and receive pending) or (`brk_ie` set and the break flag set); mode values 00 and 11 never raise a receive interrupt.
- R2: A received byte sets receive-pending and receive-in-service, sets `pend_reg` bit 5 for channel A or bit 2 for channel B, and loads the receive vector of that channel.
- R3: A transmit byte gone sets transmit-pending; only when no receive is in service does it enter transmit service, load the transmit vector, and set `pend_reg` bit 4 (A) or bit 1 (B), the latter only if that channel's `tx_ie` is set.
- R4: The vector is 0x06 none, 0x0C A receive, 0x04 B receive, 0x08 A transmit, 0x00 B transmit with `stat_hi` low; with `stat_hi` high it is 0x60, 0x30, 0x20, 0x10 and 0x00; it changes only on an event that loads it.
- R5: A command byte with bits 5:3 equal to 101 clears transmit-pending, transmit-in-service and the channel's transmit bit of `pend_reg`, loads the none vector, and when receive is pending re-enters receive service, sets the receive bit and loads the receive vector.
- R6: A command byte with bits 5:3 equal to 111 leaves receive service if it is active and then, with transmit pending, enters transmit service as in R3; otherwise it leaves transmit service; `pend_reg` and vector are unchanged when no transmit service is entered.
- R7: A data read clears receive-pending, receive-in-service and the receive bit of `pend_reg`, loads the none vector, and with transmit pending enters transmit service as in R3.
- R8: A data write clears transmit-pending without touching `pend_reg` or the vector.
- R9: The break flag is set by `brk_in` and stays set until a channel reset; a channel reset clears that channel's flags, its `pend_reg` bits and its in-service state, and leaves the vector unchanged.
- R10: After `rst_n` low, `irq` is 0, `pend_reg` is 0x00 and `vector` is 0x06.
- R11: Command bytes whose bits 5:3 are neither 101 nor 111 have no effect.
- R12: When both channels load the vector in the same cycle, channel A's value is taken; `pend_reg` bits 7, 6, 3 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 2 | Byte received strobe per channel |
| tx_done | input | 2 | Transmit byte gone strobe per channel |
| data_wr | input | 2 | Data register write strobe per channel |
| data_rd | input | 2 | Data register read strobe per channel |
| brk_in | input | 2 | Break detected strobe per channel |
| chan_rst | input | 2 | Channel reset strobe per channel |
| cmd_wr | input | 2 | Command register write strobe per channel |
| cmd_byte | input | 8 | Command byte; bits 5:3 carry the command code |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, bits 1:0 channel A, 3:2 channel B |
| brk_ie | input | 2 | Break interrupt enable per channel |
| stat_hi | input | 1 | Selects the status-high vector encoding |
| irq | output | 1 | Combined interrupt request |
| pend_reg | output | 8 | Interrupt pending register |
| vector | output | 8 | Modified interrupt vector |

## Verification
The channel assertions take for granted that a channel sees at most one of receive, transmit-gone, write, read and command in one cycle, so that the event priority inside the channel never masks what a property expects; break and channel reset may coincide with anything. The directed tasks drive each event as a single one-cycle strobe on one channel at a time, apart from the one task that fires both channels together to exercise the vector priority, and change configuration only between strobes.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int NCH      = 2;
    localparam int VEC_W    = 8;
    localparam int CODE_W   = 3;
    localparam int MODE_W   = 2;

    localparam logic [CODE_W-1:0] CMD_CLR_TX  = 3'd5;
    localparam logic [CODE_W-1:0] CMD_RST_IUS = 3'd7;

    typedef enum logic [1:0] {
        SV_IDLE = 2'd0,
        SV_RX   = 2'd1,
        SV_TX   = 2'd2,
        SV_BOTH = 2'd3
    } svc_t;

    typedef enum logic [1:0] {
        VK_NONE = 2'd0,
        VK_RX   = 2'd1,
        VK_TX   = 2'd2
    } vkind_t;

    function automatic logic [VEC_W-1:0] vec_code(input logic chan_b,
                                                  input vkind_t kind,
                                                  input logic hi);
        logic [VEC_W-1:0] v;
        unique case (kind)
            VK_RX:   v = chan_b ? (hi ? 8'h20 : 8'h04) : (hi ? 8'h30 : 8'h0C);
            VK_TX:   v = chan_b ? 8'h00 : (hi ? 8'h10 : 8'h08);
            default: v = hi ? 8'h60 : 8'h06;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sirq_chan.sv
module sirq_chan
    import sirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_byte,
    input  logic              tx_done,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic              brk_in,
    input  logic              chan_rst,
    input  logic              cmd_wr,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              tx_ie,
    input  logic [MODE_W-1:0] rx_mode,
    input  logic              brk_ie,
    output logic              req_int,
    output logic              pend_rx,
    output logic              pend_tx,
    output logic              vec_req,
    output vkind_t            vec_kind
);

    svc_t st_q, st_d;
    logic rxp_q, txp_q, brk_q, rbit_q, tbit_q;
    logic rxp_d, txp_d, brk_d, rbit_d, tbit_d;
    logic rxi, txi, rxi_d, txi_d;

    // decode in-service record
    always_comb begin
        unique case (st_q)
            SV_IDLE: begin rxi = 1'b0; txi = 1'b0; end
            SV_RX:   begin rxi = 1'b1; txi = 1'b0; end
            SV_TX:   begin rxi = 1'b0; txi = 1'b1; end
            SV_BOTH: begin rxi = 1'b1; txi = 1'b1; end
            default: begin rxi = 1'b0; txi = 1'b0; end
        endcase
    end

    // event handling, one event per cycle in priority order
    always_comb begin
        rxp_d    = rxp_q;
        txp_d    = txp_q;
        rbit_d   = rbit_q;
        tbit_d   = tbit_q;
        rxi_d    = rxi;
        txi_d    = txi;
        vec_req  = 1'b0;
        vec_kind = VK_NONE;
        brk_d    = brk_q | brk_in;
        if (chan_rst) begin
            rxp_d  = 1'b0;
            txp_d  = 1'b0;
            rbit_d = 1'b0;
            tbit_d = 1'b0;
            rxi_d  = 1'b0;
            txi_d  = 1'b0;
            brk_d  = 1'b0;
        end else if (data_rd) begin
            rxp_d   = 1'b0;
            rxi_d   = 1'b0;
            rbit_d  = 1'b0;
            vec_req = 1'b1;
            if (txp_q) begin
                txi_d    = 1'b1;
                tbit_d   = tbit_q | tx_ie;
                vec_kind = VK_TX;
            end
        end else if (data_wr) begin
            txp_d = 1'b0;
        end else if (cmd_wr && cmd_code == CMD_CLR_TX) begin
            txp_d   = 1'b0;
            txi_d   = 1'b0;
            tbit_d  = 1'b0;
            vec_req = 1'b1;
            if (rxp_q) begin
                rxi_d    = 1'b1;
                rbit_d   = 1'b1;
                vec_kind = VK_RX;
            end
        end else if (cmd_wr && cmd_code == CMD_RST_IUS) begin
            if (rxi) begin
                rxi_d = 1'b0;
                if (txp_q) begin
                    txi_d    = 1'b1;
                    tbit_d   = tbit_q | tx_ie;
                    vec_req  = 1'b1;
                    vec_kind = VK_TX;
                end
            end else begin
                txi_d = 1'b0;
            end
        end else if (rx_byte) begin
            rxp_d    = 1'b1;
            rxi_d    = 1'b1;
            rbit_d   = 1'b1;
            vec_req  = 1'b1;
            vec_kind = VK_RX;
        end else if (tx_done) begin
            txp_d = 1'b1;
            if (!rxi) begin
                txi_d    = 1'b1;
                tbit_d   = tbit_q | tx_ie;
                vec_req  = 1'b1;
                vec_kind = VK_TX;
            end
        end
    end

    // encode next in-service record
    always_comb begin
        unique case ({rxi_d, txi_d})
            2'b00:   st_d = SV_IDLE;
            2'b10:   st_d = SV_RX;
            2'b01:   st_d = SV_TX;
            default: st_d = SV_BOTH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SV_IDLE;
            rxp_q  <= 1'b0;
            txp_q  <= 1'b0;
            brk_q  <= 1'b0;
            rbit_q <= 1'b0;
            tbit_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            rxp_q  <= rxp_d;
            txp_q  <= txp_d;
            brk_q  <= brk_d;
            rbit_q <= rbit_d;
            tbit_q <= tbit_d;
        end
    end

    // outputs
    always_comb begin
        req_int = (tx_ie & txp_q)
                | (((rx_mode == 2'b01) || (rx_mode == 2'b10)) & rxp_q)
                | (brk_ie & brk_q);
        pend_rx = rbit_q;
        pend_tx = tbit_q;
    end

    logic only_ev;
    assign only_ev = !chan_rst && !data_rd && !data_wr && !cmd_wr;

    a_r2_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte && only_ev) |=> (rxp_q && pend_rx && rxi));

    a_r3_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !rx_byte && only_ev && rxi && !txi) |=> (txp_q && !txi));

    a_r5_clr_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == CMD_CLR_TX && !chan_rst && !data_rd && !data_wr)
        |=> (!txp_q && !pend_tx && !txi));

    a_r7_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !chan_rst) |=> (!rxp_q && !pend_rx && !rxi));

    a_r9_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_q && !chan_rst) |=> brk_q);

endmodule

// File: rtl/sirq_vec.sv
module sirq_vec
    import sirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req,
    input  vkind_t            kind_a,
    input  vkind_t            kind_b,
    input  logic              stat_hi,
    output logic [VEC_W-1:0]  vec
);

    logic [VEC_W-1:0] vec_q, vec_d;

    always_comb begin
        vec_d = vec_q;
        if (req[0])
            vec_d = vec_code(1'b0, kind_a, stat_hi);
        else if (req[1])
            vec_d = vec_code(1'b1, kind_b, stat_hi);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= 8'h06;
        else        vec_q <= vec_d;
    end

    assign vec = vec_q;

    a_r4_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> $stable(vec_q));

    a_r12_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req[0] && kind_a == VK_RX && !stat_hi) |=> (vec_q == 8'h0C));

endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  rx_byte,
    input  logic [1:0]  tx_done,
    input  logic [1:0]  data_wr,
    input  logic [1:0]  data_rd,
    input  logic [1:0]  brk_in,
    input  logic [1:0]  chan_rst,
    input  logic [1:0]  cmd_wr,
    input  logic [7:0]  cmd_byte,
    input  logic [1:0]  tx_ie,
    input  logic [3:0]  rx_mode,
    input  logic [1:0]  brk_ie,
    input  logic        stat_hi,
    output logic        irq,
    output logic [7:0]  pend_reg,
    output logic [7:0]  vector
);

    logic [NCH-1:0] req_int, p_rx, p_tx, v_req;
    vkind_t         v_kind [NCH];
    logic           unused_cmd_bits;

    assign unused_cmd_bits = ^{cmd_byte[7:6], cmd_byte[2:0]};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        sirq_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .rx_byte  (rx_byte[g]),
            .tx_done  (tx_done[g]),
            .data_wr  (data_wr[g]),
            .data_rd  (data_rd[g]),
            .brk_in   (brk_in[g]),
            .chan_rst (chan_rst[g]),
            .cmd_wr   (cmd_wr[g]),
            .cmd_code (cmd_byte[5:3]),
            .tx_ie    (tx_ie[g]),
            .rx_mode  (rx_mode[MODE_W*g +: MODE_W]),
            .brk_ie   (brk_ie[g]),
            .req_int  (req_int[g]),
            .pend_rx  (p_rx[g]),
            .pend_tx  (p_tx[g]),
            .vec_req  (v_req[g]),
            .vec_kind (v_kind[g])
        );
    end

    sirq_vec u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (v_req),
        .kind_a  (v_kind[0]),
        .kind_b  (v_kind[1]),
        .stat_hi (stat_hi),
        .vec     (vector)
    );

    assign irq      = |req_int;
    assign pend_reg = {2'b00, p_rx[0], p_tx[0], 1'b0, p_rx[1], p_tx[1], 1'b0};

    a_r10_reset_quiet: assert property (@(posedge clk)
        (!rst_n) |=> (!irq && pend_reg == 8'h00 && vector == 8'h06));

endmodule

// File: tb/tb_sirq_ctrl.sv
module tb_sirq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] rx_byte, tx_done, data_wr, data_rd, brk_in, chan_rst, cmd_wr;
    logic [7:0] cmd_byte;
    logic [1:0] tx_ie, brk_ie;
    logic [3:0] rx_mode;
    logic       stat_hi;
    logic       irq;
    logic [7:0] pend_reg, vector;

    int total = 0;
    int bad   = 0;

    localparam int EV_RX = 0, EV_TXD = 1, EV_WR = 2, EV_RD = 3,
                   EV_BRK = 4, EV_RST = 5, EV_CMD = 6;

    sirq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .tx_done(tx_done),
        .data_wr(data_wr), .data_rd(data_rd), .brk_in(brk_in),
        .chan_rst(chan_rst), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .tx_ie(tx_ie), .rx_mode(rx_mode), .brk_ie(brk_ie),
        .stat_hi(stat_hi), .irq(irq), .pend_reg(pend_reg), .vector(vector)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%02h expected=0x%02h", req, what, act, exp);
        end
    endtask

    task automatic chk3(input string req, input logic i, input logic [7:0] p,
                        input logic [7:0] v);
        chk(req, "irq", {7'd0, irq}, {7'd0, i});
        chk(req, "pend_reg", pend_reg, p);
        chk(req, "vector", vector, v);
    endtask

    task automatic clear_strobes();
        rx_byte = 0; tx_done = 0; data_wr = 0; data_rd = 0;
        brk_in = 0; chan_rst = 0; cmd_wr = 0; cmd_byte = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_strobes();
        tx_ie = 2'b11; brk_ie = 2'b11; rx_mode = 4'b0101; stat_hi = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fire(input int kind, input int ch, input logic [7:0] cb);
        case (kind)
            EV_RX:  rx_byte[ch]  = 1'b1;
            EV_TXD: tx_done[ch]  = 1'b1;
            EV_WR:  data_wr[ch]  = 1'b1;
            EV_RD:  data_rd[ch]  = 1'b1;
            EV_BRK: brk_in[ch]   = 1'b1;
            EV_RST: chan_rst[ch] = 1'b1;
            default: begin cmd_wr[ch] = 1'b1; cmd_byte = cb; end
        endcase
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic t_reset();
        do_reset();
        chk3("R10", 1'b0, 8'h00, 8'h06);
    endtask

    task automatic t_rx_read_a();
        do_reset();
        fire(EV_RX, 0, 0);
        chk3("R2", 1'b1, 8'h20, 8'h0C);
        fire(EV_RD, 0, 0);
        chk3("R7", 1'b0, 8'h00, 8'h06);
    endtask

    task automatic t_tx_held_b();
        do_reset();
        stat_hi = 1'b1;
        fire(EV_RX, 1, 0);
        chk3("R2", 1'b1, 8'h04, 8'h20);
        fire(EV_TXD, 1, 0);
        chk3("R3", 1'b1, 8'h04, 8'h20);
        fire(EV_RD, 1, 0);
        chk3("R7", 1'b1, 8'h02, 8'h00);
    endtask

    task automatic t_tx_enable_write_a();
        do_reset();
        tx_ie = 2'b10;
        fire(EV_TXD, 0, 0);
        chk3("R3", 1'b0, 8'h00, 8'h08);
        @(negedge clk);
        tx_ie = 2'b11;
        #1;
        chk("R1", "irq", {7'd0, irq}, 8'h01);
        fire(EV_WR, 0, 0);
        chk3("R8", 1'b0, 8'h00, 8'h08);
        fire(EV_TXD, 0, 0);
        chk3("R3", 1'b1, 8'h10, 8'h08);
        fire(EV_WR, 0, 0);
        chk3("R8", 1'b0, 8'h10, 8'h08);
        fire(EV_CMD, 0, 8'h28);
        chk3("R5", 1'b0, 8'h00, 8'h06);
        stat_hi = 1'b1;
        fire(EV_CMD, 0, 8'h28);
        chk3("R4", 1'b0, 8'h00, 8'h60);
    endtask

    task automatic t_clr_tx_rearms_rx();
        do_reset();
        fire(EV_TXD, 0, 0);
        fire(EV_RX, 0, 0);
        chk3("R2", 1'b1, 8'h30, 8'h0C);
        fire(EV_CMD, 0, 8'h28);
        chk3("R5", 1'b1, 8'h20, 8'h0C);
    endtask

    task automatic t_reset_ius();
        do_reset();
        fire(EV_RX, 0, 0);
        fire(EV_TXD, 0, 0);
        chk3("R3", 1'b1, 8'h20, 8'h0C);
        fire(EV_CMD, 0, 8'h38);
        chk3("R6", 1'b1, 8'h30, 8'h08);
        fire(EV_CMD, 0, 8'h38);
        chk3("R6", 1'b1, 8'h30, 8'h08);
    endtask

    task automatic t_rx_modes_hi();
        do_reset();
        stat_hi = 1'b1;
        fire(EV_RX, 0, 0);
        chk3("R4", 1'b1, 8'h20, 8'h30);
        stat_hi = 1'b0;
        rx_mode = 4'b0111;
        #1;
        chk("R1", "irq mode 11", {7'd0, irq}, 8'h00);
        rx_mode = 4'b0110;
        #1;
        chk("R1", "irq mode 10", {7'd0, irq}, 8'h01);
        rx_mode = 4'b0100;
        #1;
        chk("R1", "irq mode 00", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_break_b();
        do_reset();
        fire(EV_BRK, 1, 0);
        chk3("R1", 1'b1, 8'h00, 8'h06);
        brk_ie = 2'b01;
        #1;
        chk("R1", "irq brk disabled", {7'd0, irq}, 8'h00);
        brk_ie = 2'b11;
        repeat (3) @(negedge clk);
        chk("R9", "irq brk sticky", {7'd0, irq}, 8'h01);
        fire(EV_RX, 1, 0);
        chk3("R9", 1'b1, 8'h04, 8'h04);
        fire(EV_RST, 1, 0);
        chk3("R9", 1'b0, 8'h00, 8'h04);
    endtask

    task automatic t_ignored_cmds();
        do_reset();
        fire(EV_TXD, 0, 0);
        chk3("R3", 1'b1, 8'h10, 8'h08);
        fire(EV_CMD, 0, 8'h20);
        chk3("R11", 1'b1, 8'h10, 8'h08);
        fire(EV_CMD, 0, 8'hC7);
        chk3("R11", 1'b1, 8'h10, 8'h08);
    endtask

    task automatic t_both_rx();
        do_reset();
        rx_byte = 2'b11;
        @(negedge clk);
        clear_strobes();
        chk3("R12", 1'b1, 8'h24, 8'h0C);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        clear_strobes();
        tx_ie = 2'b11; brk_ie = 2'b11; rx_mode = 4'b0101; stat_hi = 1'b0;
        t_reset();
        t_rx_read_a();
        t_tx_held_b();
        t_tx_enable_write_a();
        t_clr_tx_rearms_rx();
        t_reset_ius();
        t_rx_modes_hi();
        t_break_b();
        t_ignored_cmds();
        t_both_rx();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule